// File: doc/BRIEF.md
# Byte-Oriented SPI Slave Port

This block is an SPI slave that lives entirely in the system clock domain. The external serial clock, data-in and active-low select lines are each brought in through a two-flop synchronizer. Serial clock edges are found by comparing the synchronized sample with the one taken a cycle earlier, so the serial clock must run at no more than one eighth of the system clock.

The select line acts on its edges, not its level. A falling edge switches the port on and a rising edge switches it off. Only serial clock edges seen while the port is on move the shifter. Ending the select partway through a byte leaves the bit count and shift contents where they were, and only an explicit flush discards them. The serial output is driven at all times.

Software-side logic loads outgoing bytes into a one-entry transmit buffer and collects incoming bytes from a one-entry receive buffer. A one-cycle transmit pulse marks the moment a byte is committed to the shifter. If no new byte was written by then, the previous byte is sent again.

Top module: `spi_slave_port`

## Requirements
- R1: After reset, miso_out is 0, rx_valid is 0, rx_overrun is 0, tx_irq is 0 and tx_empty is 1.
- R2: A falling edge on sel_n_in makes the port active and a rising edge makes it inactive. Serial clock edges seen while inactive change neither the bit count nor the shift contents, so rx_valid does not rise and miso_out holds its value.
- R3: cpol gives the idle level of sck_in; the leading edge leaves the idle level. With cpha=0, data is sampled on the leading edge and miso_out moves on the trailing edge, with the first bit present before the first leading edge. With cpha=1, miso_out moves on the leading edge and data is sampled on the trailing edge.
- R4: lsb_first=0 sends and receives bit 7 first; lsb_first=1 sends and receives bit 0 first. Both directions use the same order.
- R5: When the eighth bit of a byte is sampled, the received byte appears on rx_data and rx_valid is set. rx_valid stays set until a one-cycle pulse on rx_read clears it.
- R6: If a byte completes while rx_valid is still set and rx_read is not asserted, rx_overrun is set and rx_data takes the new byte. rx_read clears rx_overrun.
- R7: tx_irq is a single-cycle pulse, issued once per byte when the next outgoing byte is loaded into the shifter. The load happens when the port becomes active with nothing loaded, and again right after each byte completes.
- R8: tx_write stores tx_data and clears tx_empty. A load sets tx_empty again. If tx_empty is set at load time, the previously sent byte is shifted out again.
- R9: If sel_n_in rises partway through a byte, the partial state is kept. After reselection the remaining bits complete that same byte.
- R10: A one-cycle pulse on flush clears the bit count and the shift contents. The next transfer starts at its first bit.
- R11: miso_out is never high-impedance or unknown after reset, including while the port is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| flush | input | 1 | Discard any partial byte |
| sck_in | input | 1 | External serial clock (asynchronous) |
| mosi_in | input | 1 | External serial data in (asynchronous) |
| sel_n_in | input | 1 | External active-low select, edge-acting |
| miso_out | output | 1 | Serial data out, always driven |
| tx_data | input | W | Byte to transmit |
| tx_write | input | 1 | Store tx_data into the transmit buffer |
| tx_empty | output | 1 | Transmit buffer holds no new byte |
| tx_irq | output | 1 | One-cycle pulse when a byte is loaded for sending |
| rx_data | output | W | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_read | input | 1 | Acknowledge rx_data |
| rx_overrun | output | 1 | A byte arrived before the previous one was read |

## Verification
The bench drives all four clock modes in both bit orders and compares the captured output byte and the received byte with the stimulus. A design that picks the wrong edge or shifts on the first edge of a byte would return a byte rotated by one bit.

Several corner cases get their own scenario. Deselecting mid-byte and toggling the serial clock while deselected catches a design that clears state on select or that counts edges while idle. Such a design would either lose the first half of the byte or assemble a shifted one. A flush after a few junk bits checks that the following byte arrives aligned. Two unread bytes in a row must raise the overrun flag while keeping the newer byte. A burst with no fresh transmit data must resend the previous byte and produce exactly one transmit pulse per byte.

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         flush,
  input  logic         sck_in,
  input  logic         mosi_in,
  input  logic         sel_n_in,
  output logic         miso_out,
  input  logic [W-1:0] tx_data,
  input  logic         tx_write,
  output logic         tx_empty,
  output logic         tx_irq,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         rx_read,
  output logic         rx_overrun
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  function automatic logic [W-1:0] order(input logic [W-1:0] d, input logic rev);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = d[W-1-i];
    return rev ? r : d;
  endfunction

  logic [1:0]    sck_s, mosi_s, sel_s;
  logic          sck_q, sel_q;
  logic          active, loaded, tx_full;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh_tx, sh_rx, tx_buf, last_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      sel_s  <= 2'b11;
      sck_q  <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sck_s  <= {sck_s[0], sck_in};
      mosi_s <= {mosi_s[0], mosi_in};
      sel_s  <= {sel_s[0], sel_n_in};
      sck_q  <= sck_s[1];
      sel_q  <= sel_s[1];
    end
  end

  wire sck_r  = sck_s[1] & ~sck_q;
  wire sck_f  = ~sck_s[1] & sck_q;
  wire lead   = cpol ? sck_f : sck_r;
  wire trail  = cpol ? sck_r : sck_f;
  wire samp_e = active & (cpha ? trail : lead);
  wire drv_e  = active & (cpha ? lead : trail) & (cnt != '0);
  wire sel_fall = sel_q & ~sel_s[1];
  wire sel_rise = ~sel_q & sel_s[1];
  wire done   = samp_e & (cnt == LAST);
  wire load   = active & ~loaded & ~flush;
  wire [W-1:0] rx_next = {sh_rx[W-2:0], mosi_s[1]};

  assign miso_out = sh_tx[W-1];
  assign tx_empty = ~tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else if (sel_fall) active <= 1'b1;
    else if (sel_rise) active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      loaded <= 1'b0;
    end else if (flush) begin
      cnt    <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
      loaded <= 1'b0;
    end else begin
      if (load) begin
        sh_tx  <= order(tx_full ? tx_buf : last_tx, lsb_first);
        loaded <= 1'b1;
      end else if (drv_e) begin
        sh_tx <= sh_tx << 1;
      end
      if (samp_e) begin
        sh_rx <= rx_next;
        cnt   <= done ? '0 : cnt + 1'b1;
      end
      if (done) loaded <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      last_tx <= '0;
      tx_full <= 1'b0;
      tx_irq  <= 1'b0;
    end else begin
      tx_irq <= load;
      if (load) last_tx <= tx_full ? tx_buf : last_tx;
      if (tx_write) tx_buf <= tx_data;
      tx_full <= (tx_full & ~load) | tx_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (done) rx_data <= order(rx_next, lsb_first);
      if (done) rx_valid <= 1'b1;
      else if (rx_read) rx_valid <= 1'b0;
      if (done & rx_valid & ~rx_read) rx_overrun <= 1'b1;
      else if (rx_read) rx_overrun <= 1'b0;
    end
  end

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  a_r5_valid_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid);
  a_r6_overrun_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);
  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !flush && !$rose(active)) |=> $stable(cnt) && $stable(sh_rx));
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0) && (sh_rx == '0));
  a_r8_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !$past(tx_write)) |-> tx_empty);
  a_r11_miso_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(miso_out));
endmodule

// File: tb/spi_slave_port_tb.sv
module spi_slave_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0, flush = 0;
  logic sck = 0, mosi = 0, sel_n = 1;
  logic [7:0] tx_data = '0;
  logic tx_write = 0, rx_read = 0;
  logic miso, tx_empty, tx_irq, rx_valid, rx_overrun;
  logic [7:0] rx_data;
  logic [7:0] cap;
  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_slave_port #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb),
    .flush(flush), .sck_in(sck), .mosi_in(mosi), .sel_n_in(sel_n),
    .miso_out(miso), .tx_data(tx_data), .tx_write(tx_write), .tx_empty(tx_empty),
    .tx_irq(tx_irq), .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
    .rx_overrun(rx_overrun));

  always @(negedge clk) if (rst_n && tx_irq) irq_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1; @(negedge clk); flush = 0; repeat (2) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rx_read = 1; @(negedge clk); rx_read = 0; @(negedge clk);
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_write = 1; @(negedge clk); tx_write = 0;
  endtask

  task automatic sel(input logic v);
    @(negedge clk); sel_n = v; half();
  endtask

  task automatic bits(input logic [7:0] mo, input int from, input int to);
    for (int i = from; i <= to; i++) begin
      int b;
      b = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi = mo[b]; half(); cap[b] = miso; sck = ~cpol; half(); sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[b]; half(); cap[b] = miso; sck = cpol; half();
      end
    end
    half();
  endtask

  task automatic set_mode(input logic p, input logic h, input logic l);
    @(negedge clk); cpol = p; cpha = h; lsb = l; sck = p; half();
  endtask

  task automatic t_reset();
    chk("R1 miso", miso, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 overrun", rx_overrun, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 tx_empty", tx_empty, 1);
  endtask

  task automatic t_mode(input logic p, input logic h, input logic l,
                        input logic [7:0] txb, input logic [7:0] rxb);
    set_mode(p, h, l);
    pulse_flush();
    put_tx(txb);
    chk("R8 tx_empty after write", tx_empty, 0);
    sel(0);
    chk("R8 tx_empty after load", tx_empty, 1);
    cap = '0;
    bits(rxb, 0, 7);
    chk($sformatf("R3 R4 miso byte mode %0d%0d lsb %0d", p, h, l), cap, txb);
    chk("R5 rx_data", rx_data, rxb);
    chk("R5 rx_valid", rx_valid, 1);
    do_read();
    chk("R5 rx_valid cleared", rx_valid, 0);
    sel(1);
  endtask

  task automatic t_repeat();
    int c0;
    set_mode(0, 0, 0);
    pulse_flush();
    put_tx(8'h96);
    sel(0);
    bits(8'h11, 0, 7);
    do_read();
    c0 = irq_cnt;
    cap = '0;
    bits(8'h22, 0, 7);
    chk("R8 repeat last byte", cap, 8'h96);
    chk("R7 one irq per byte", irq_cnt - c0, 1);
    do_read();
    sel(1);
  endtask

  task automatic t_overrun();
    set_mode(1, 1, 0);
    pulse_flush();
    sel(0);
    bits(8'h5A, 0, 7);
    chk("R6 no overrun on first", rx_overrun, 0);
    bits(8'hC3, 0, 7);
    chk("R6 overrun set", rx_overrun, 1);
    chk("R6 newest byte kept", rx_data, 8'hC3);
    do_read();
    chk("R6 overrun cleared", rx_overrun, 0);
    sel(1);
  endtask

  task automatic t_partial();
    logic m0;
    set_mode(0, 0, 0);
    pulse_flush();
    put_tx(8'hE1);
    sel(0);
    cap = '0;
    bits(8'hB4, 0, 3);
    sel(1);
    m0 = miso;
    for (int k = 0; k < 4; k++) begin
      sck = 1; half(); sck = 0; half();
    end
    chk("R2 no byte while deselected", rx_valid, 0);
    chk("R2 miso held while deselected", miso, m0);
    chk("R11 miso driven", $isunknown(miso), 0);
    sel(0);
    bits(8'hB4, 4, 7);
    chk("R9 split byte received", rx_data, 8'hB4);
    chk("R9 split byte sent", cap, 8'hE1);
    do_read();
    sel(1);
  endtask

  task automatic t_flush();
    set_mode(0, 1, 1);
    pulse_flush();
    sel(0);
    bits(8'hFF, 0, 2);
    pulse_flush();
    chk("R10 no byte after flush", rx_valid, 0);
    bits(8'h4D, 0, 7);
    chk("R10 aligned after flush", rx_data, 8'h4D);
    chk("R10 rx_valid", rx_valid, 1);
    do_read();
    sel(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_mode(0, 0, 0, 8'hA5, 8'h3C);
    t_mode(0, 1, 0, 8'h81, 8'h7E);
    t_mode(1, 0, 1, 8'h13, 8'hC8);
    t_mode(1, 1, 1, 8'h6B, 8'h29);
    t_repeat();
    t_overrun();
    t_partial();
    t_flush();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule